// File: doc/BRIEF.md
# No-Turnaround Synchronous SRAM Model

This block is a synthesizable model of a synchronous static RAM whose data bus can carry reads and writes in any order on consecutive clocks with no idle cycles between them. Address, command and byte enables are taken on the rising clock edge. The data for a write reaches the bus after its address, one or two edges later. This late-write offset matches the read latency, so a read slot and a write slot never need the bus in the same cycle.

A mode input selects one of two read paths. In flow-through mode the data appears one edge after the command. In pipelined mode it passes through an extra output register and appears one edge later still. Writes that have been issued but are still waiting for their data sit in a short queue. A read of one of those addresses takes the newer bytes from the queue and the bus instead of the stale array word. Three chip selects allow depth expansion. An asynchronous output enable and a sleep input complete the control set. The mode may change only while no write is waiting for its data.

Top module: `nbt_sram`

## Requirements
- R1: While `rst` is high, `dq_oe` is 0 on the following cycle, and no command taken at an edge where `rst` is high has any effect.
- R2: In flow-through mode (`mode_pipe`=0), a read taken at edge n drives `dq_oe`=1 and the addressed word on `dq_o` for the cycle after edge n only.
- R3: In pipelined mode (`mode_pipe`=1), a read taken at edge n drives `dq_o` for the cycle after edge n+1 only, and `dq_oe` stays 0 in the cycle after edge n unless an earlier read owns that slot.
- R4: In flow-through mode, the write data for an address taken at edge n is sampled from `wr_data` at edge n+1.
- R5: In pipelined mode, the write data for an address taken at edge n is sampled from `wr_data` at edge n+2.
- R6: Byte lane i is bits [9i+8:9i] of the word, and it is written only when `byte_en[i]` is 1. The other lanes keep their contents.
- R7: A command is taken only when `sel_a_n`=0, `sel_b`=1 and `sel_c_n`=0. Otherwise the cycle is idle: nothing is written and nothing is driven.
- R8: `oe_n`=1 forces `dq_oe` to 0 at once, without a clock edge. Read data already in flight is driven again as soon as `oe_n` returns to 0 within its slot.
- R9: While `sleep`=1, new commands are ignored: a read drives nothing, a write changes nothing, and the memory contents are kept.
- R10: A read of an address with a write still waiting for its data returns that write's bytes in its enabled lanes, so reads and writes can alternate on every clock.
- R11: `wr_en`=1 makes a selected command a write, and `wr_en`=0 makes it a read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| mode_pipe | input | 1 | 1 = pipelined reads with two-edge write data, 0 = flow-through reads with one-edge write data |
| sel_a_n | input | 1 | Chip select, active low |
| sel_b | input | 1 | Chip select, active high |
| sel_c_n | input | 1 | Chip select, active low |
| wr_en | input | 1 | 1 = write command, 0 = read command |
| byte_en | input | NL | Per-lane write enables, active high |
| addr | input | AW | Word address |
| wr_data | input | NL*LW | Late write data |
| oe_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Asynchronous sleep, active high; blocks new commands |
| dq_o | output | NL*LW | Read data |
| dq_oe | output | 1 | Bus driver enable; 0 means the bus is released to high impedance |

## Verification
The bench uses the default parameters: 16 words of four 9-bit lanes. With this size, a handful of addresses is enough to make pending writes collide with reads. The stimulus covers every lane-mask shape and both bypass sources: the write committing at the read's own edge, and the pipelined write whose data arrives one edge after the read. Flow-through and pipelined traffic run in separate segments, so each mode's read slots and late-write offsets are seen in back-to-back read, write, read sequences.

// File: rtl/nbt_sram_pkg.sv
package nbt_sram_pkg;
  typedef enum logic {
    MODE_FLOW = 1'b0,
    MODE_PIPE = 1'b1
  } rd_mode_e;

  // Control flags of one pending late-write slot.
  typedef struct packed {
    logic valid;
    logic pipe;
  } slot_ctl_t;
endpackage

// File: rtl/nbt_sram_wq.sv
module nbt_sram_wq
  import nbt_sram_pkg::*;
#(
  parameter int AW = 4,
  parameter int NL = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  rd_mode_e      push_mode,
  input  logic [AW-1:0] push_addr,
  input  logic [NL-1:0] push_be,
  output logic          cm_valid,
  output logic [AW-1:0] cm_addr,
  output logic [NL-1:0] cm_be,
  output logic          lt_valid,
  output logic [AW-1:0] lt_addr,
  output logic [NL-1:0] lt_be
);
  slot_ctl_t     s0_ctl, s1_ctl;
  logic [AW-1:0] s0_addr, s1_addr;
  logic [NL-1:0] s0_be, s1_be;

  always_ff @(posedge clk) begin
    if (rst) begin
      s0_ctl <= '0;
      s1_ctl <= '0;
    end else begin
      s0_ctl.valid <= push;
      s0_ctl.pipe  <= (push_mode == MODE_PIPE);
      s1_ctl.valid <= s0_ctl.valid & s0_ctl.pipe;
      s1_ctl.pipe  <= 1'b1;
    end
    s0_addr <= push_addr;
    s0_be   <= push_be;
    s1_addr <= s0_addr;
    s1_be   <= s0_be;
  end

  // The older slot commits first; a flow-through entry commits after one stage.
  always_comb begin
    cm_valid = s1_ctl.valid | (s0_ctl.valid & ~s0_ctl.pipe);
    cm_addr  = s1_ctl.valid ? s1_addr : s0_addr;
    cm_be    = s1_ctl.valid ? s1_be : s0_be;
    lt_valid = s0_ctl.valid & s0_ctl.pipe;
    lt_addr  = s0_addr;
    lt_be    = s0_be;
  end
endmodule

// File: rtl/nbt_sram_array.sv
module nbt_sram_array #(
  parameter int AW = 4,
  parameter int NL = 4,
  parameter int LW = 9
) (
  input  logic             clk,
  input  logic             we,
  input  logic [NL-1:0]    wbe,
  input  logic [AW-1:0]    waddr,
  input  logic [NL*LW-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [NL*LW-1:0] rd_q
);
  localparam int DEPTH = 1 << AW;

  for (genvar g = 0; g < NL; g++) begin : g_lane
    logic [LW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
      if (we && wbe[g]) mem[waddr] <= wdata[g*LW +: LW];
      rd_q[g*LW +: LW] <= mem[raddr];
    end
  end
endmodule

// File: rtl/nbt_sram_rdpath.sv
module nbt_sram_rdpath #(
  parameter int NL = 4,
  parameter int LW = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rd_acc,
  input  logic             rd_pipe,
  input  logic [NL*LW-1:0] raw,
  input  logic [NL-1:0]    cm_hit_be,
  input  logic [NL-1:0]    lt_hit_be,
  input  logic [NL*LW-1:0] wr_data,
  output logic             drive,
  output logic [NL*LW-1:0] data
);
  localparam int DW = NL * LW;

  logic          f_v, f_pipe, p_v;
  logic [DW-1:0] byp_d, flow_val, p_d;
  logic [NL-1:0] byp_be, late_be;

  always_ff @(posedge clk) begin
    if (rst) begin
      f_v <= 1'b0;
      p_v <= 1'b0;
    end else begin
      f_v <= rd_acc;
      p_v <= f_v & f_pipe;
    end
    f_pipe  <= rd_pipe;
    byp_d   <= wr_data;
    byp_be  <= rd_acc ? cm_hit_be : '0;
    late_be <= (rd_acc && rd_pipe) ? lt_hit_be : '0;
  end

  for (genvar g = 0; g < NL; g++) begin : g_merge
    assign flow_val[g*LW +: LW] = byp_be[g] ? byp_d[g*LW +: LW] : raw[g*LW +: LW];

    always_ff @(posedge clk) begin
      p_d[g*LW +: LW] <= late_be[g] ? wr_data[g*LW +: LW] : flow_val[g*LW +: LW];
    end
  end

  assign drive = (f_v & ~f_pipe) | p_v;
  assign data  = p_v ? p_d : flow_val;
endmodule

// File: rtl/nbt_sram.sv
module nbt_sram
  import nbt_sram_pkg::*;
#(
  parameter int AW = 4,
  parameter int NL = 4,
  parameter int LW = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mode_pipe,
  input  logic             sel_a_n,
  input  logic             sel_b,
  input  logic             sel_c_n,
  input  logic             wr_en,
  input  logic [NL-1:0]    byte_en,
  input  logic [AW-1:0]    addr,
  input  logic [NL*LW-1:0] wr_data,
  input  logic             oe_n,
  input  logic             sleep,
  output logic [NL*LW-1:0] dq_o,
  output logic             dq_oe
);
  localparam int DW = NL * LW;

  rd_mode_e      mode;
  logic          accept, rd_acc, wr_acc;
  logic          cm_valid, lt_valid, drive;
  logic [AW-1:0] cm_addr, lt_addr;
  logic [NL-1:0] cm_be, lt_be, cm_hit_be, lt_hit_be;
  logic [DW-1:0] raw;

  assign mode   = mode_pipe ? MODE_PIPE : MODE_FLOW;
  assign accept = ~sel_a_n & sel_b & ~sel_c_n & ~sleep;
  assign rd_acc = accept & ~wr_en;
  assign wr_acc = accept & wr_en;

  nbt_sram_wq #(.AW(AW), .NL(NL)) wq_i (
    .clk(clk), .rst(rst), .push(wr_acc), .push_mode(mode),
    .push_addr(addr), .push_be(byte_en),
    .cm_valid(cm_valid), .cm_addr(cm_addr), .cm_be(cm_be),
    .lt_valid(lt_valid), .lt_addr(lt_addr), .lt_be(lt_be)
  );

  nbt_sram_array #(.AW(AW), .NL(NL), .LW(LW)) arr_i (
    .clk(clk), .we(cm_valid), .wbe(cm_be), .waddr(cm_addr),
    .wdata(wr_data), .raddr(addr), .rd_q(raw)
  );

  assign cm_hit_be = (cm_valid && cm_addr == addr) ? cm_be : '0;
  assign lt_hit_be = (lt_valid && lt_addr == addr) ? lt_be : '0;

  nbt_sram_rdpath #(.NL(NL), .LW(LW)) rd_i (
    .clk(clk), .rst(rst), .rd_acc(rd_acc), .rd_pipe(mode == MODE_PIPE),
    .raw(raw), .cm_hit_be(cm_hit_be), .lt_hit_be(lt_hit_be),
    .wr_data(wr_data), .drive(drive), .data(dq_o)
  );

  assign dq_oe = drive & ~oe_n;
endmodule

// File: rtl/nbt_sram_chk.sv
module nbt_sram_chk (
  input logic clk,
  input logic rst,
  input logic mode_pipe,
  input logic sel_a_n,
  input logic sel_b,
  input logic sel_c_n,
  input logic wr_en,
  input logic sleep,
  input logic oe_n,
  input logic dq_oe
);
  logic rd_ok;
  assign rd_ok = !sel_a_n && sel_b && !sel_c_n && !sleep && !wr_en;

  // R1
  reset_idle_chk: assert property (@(posedge clk) rst |=> !dq_oe);

  // R8
  oe_release_chk: assert property (@(posedge clk) disable iff (rst) oe_n |-> !dq_oe);

  // R2
  flow_slot_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_ok && !mode_pipe) |=> (dq_oe || oe_n));

  // R3
  pipe_slot_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_ok && mode_pipe) |-> ##2 (dq_oe || oe_n));

  // R7 R9
  no_cmd_chk: assert property (@(posedge clk) disable iff (rst)
    (dq_oe && !mode_pipe && !$past(mode_pipe) && !$past(mode_pipe, 2)) |-> $past(rd_ok));
endmodule

bind nbt_sram nbt_sram_chk chk_i (
  .clk(clk), .rst(rst), .mode_pipe(mode_pipe), .sel_a_n(sel_a_n),
  .sel_b(sel_b), .sel_c_n(sel_c_n), .wr_en(wr_en), .sleep(sleep),
  .oe_n(oe_n), .dq_oe(dq_oe)
);

// File: tb/nbt_sram_tb_top.sv
module nbt_sram_tb_top;
  localparam int AW = 4;
  localparam int NL = 4;
  localparam int LW = 9;
  localparam int DW = NL * LW;
  localparam int NV = 23;
  localparam int NC = NV + 4;
  localparam logic [DW-1:0] JUNK = 36'hBADBADBAD;

  // {mode_pipe, wr, selected, addr[4], byte_en[4], data[36]}
  localparam logic [46:0] VEC [NV] = '{
    {1'b0, 1'b1, 1'b1, 4'd3, 4'hF, 36'h111111111},  // 0  flow write R4
    {1'b0, 1'b0, 1'b1, 4'd3, 4'h0, 36'h0},          // 1  read, commit bypass R10
    {1'b0, 1'b1, 1'b1, 4'd3, 4'h5, 36'hAAAAAAAAA},  // 2  lane mask R6
    {1'b0, 1'b0, 1'b1, 4'd3, 4'h0, 36'h0},          // 3  R6 R10
    {1'b0, 1'b1, 1'b1, 4'd5, 4'hF, 36'h123456789},  // 4
    {1'b0, 1'b1, 1'b1, 4'd6, 4'hF, 36'hFEDCBA987},  // 5
    {1'b0, 1'b0, 1'b1, 4'd5, 4'h0, 36'h0},          // 6  R11
    {1'b0, 1'b1, 1'b1, 4'd5, 4'h8, 36'h000000000},  // 7
    {1'b0, 1'b0, 1'b1, 4'd6, 4'h0, 36'h0},          // 8
    {1'b0, 1'b0, 1'b1, 4'd5, 4'h0, 36'h0},          // 9
    {1'b0, 1'b1, 1'b0, 4'd6, 4'hF, 36'h000000000},  // 10 deselected R7
    {1'b0, 1'b0, 1'b1, 4'd6, 4'h0, 36'h0},          // 11 R7
    {1'b0, 1'b0, 1'b0, 4'd0, 4'h0, 36'h0},          // 12 idle
    {1'b1, 1'b1, 1'b1, 4'd7, 4'hF, 36'h0F0F0F0F0},  // 13 pipe write R5
    {1'b1, 1'b0, 1'b1, 4'd7, 4'h0, 36'h0},          // 14 late bypass R10
    {1'b1, 1'b1, 1'b1, 4'd7, 4'h3, 36'hFFFFFFFFF},  // 15
    {1'b1, 1'b0, 1'b1, 4'd7, 4'h0, 36'h0},          // 16 R3 R10
    {1'b1, 1'b0, 1'b1, 4'd3, 4'h0, 36'h0},          // 17
    {1'b1, 1'b1, 1'b1, 4'd3, 4'h1, 36'h000000001},  // 18
    {1'b1, 1'b1, 1'b1, 4'd8, 4'hF, 36'h555555555},  // 19
    {1'b1, 1'b0, 1'b1, 4'd3, 4'h0, 36'h0},          // 20
    {1'b1, 1'b0, 1'b1, 4'd8, 4'h0, 36'h0},          // 21
    {1'b1, 1'b0, 1'b0, 4'd0, 4'h0, 36'h0}           // 22 idle
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          mode_pipe = 1'b0, sel_a_n = 1'b1, sel_b = 1'b0, sel_c_n = 1'b1;
  logic          wr_en = 1'b0, oe_n = 1'b0, sleep = 1'b0;
  logic [NL-1:0] byte_en = '0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wr_data = JUNK;
  logic [DW-1:0] dq_o;
  logic          dq_oe;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [DW-1:0] refm [1 << AW];
  logic [DW-1:0] busd [NC];
  logic          exp_oe [NC];
  logic [DW-1:0] exp_d [NC];
  string         exp_req [NC];

  always #2 clk = ~clk;

  nbt_sram #(.AW(AW), .NL(NL), .LW(LW)) dut_i (
    .clk(clk), .rst(rst), .mode_pipe(mode_pipe), .sel_a_n(sel_a_n),
    .sel_b(sel_b), .sel_c_n(sel_c_n), .wr_en(wr_en), .byte_en(byte_en),
    .addr(addr), .wr_data(wr_data), .oe_n(oe_n), .sleep(sleep),
    .dq_o(dq_o), .dq_oe(dq_oe)
  );

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cmd(input logic pm, input logic wr, input logic sel,
                     input logic [AW-1:0] a, input logic [NL-1:0] be);
    mode_pipe = pm;
    wr_en     = wr;
    sel_a_n   = ~sel;
    sel_b     = sel;
    sel_c_n   = ~sel;
    addr      = a;
    byte_en   = be;
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(4 * 20000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // Expected values from the requirements
    for (int i = 0; i < NC; i++) begin
      busd[i] = JUNK; exp_oe[i] = 1'b0; exp_d[i] = '0; exp_req[i] = "R2/R3 idle slot";
    end
    for (int k = 0; k < NV; k++) begin
      logic [46:0] v;
      int slot;
      v = VEC[k];
      if (v[44]) begin
        if (v[45]) begin
          busd[k + (v[46] ? 2 : 1)] = v[35:0];  // R4 R5
          for (int l = 0; l < NL; l++)
            if (v[36 + l]) refm[v[43:40]][l*LW +: LW] = v[l*LW +: LW];
        end else begin
          slot = k + (v[46] ? 1 : 0);
          exp_oe[slot] = 1'b1;
          exp_d[slot]  = refm[v[43:40]];
          exp_req[slot] = v[46] ? "R3 R10 pipelined read" : "R2 R10 flow read";
        end
      end
    end

    // R1: reset state
    repeat (3) tick();
    check("R1 reset dq_oe", DW'(dq_oe), DW'(0));
    rst = 1'b0;

    // Table walk
    for (int k = 0; k < NC; k++) begin
      if (k < NV) cmd(VEC[k][46], VEC[k][45], VEC[k][44], VEC[k][43:40], VEC[k][39:36]);
      else cmd(1'b0, 1'b0, 1'b0, '0, '0);
      wr_data = busd[k];
      tick();
      check(exp_req[k], DW'(dq_oe), DW'(exp_oe[k]));
      if (exp_oe[k]) check(exp_req[k], dq_o, exp_d[k]);
    end

    // R8: asynchronous output enable
    cmd(1'b0, 1'b0, 1'b1, 4'd6, '0);
    tick();
    check("R2 flow read a6", dq_o, refm[6]);
    cmd(1'b0, 1'b0, 1'b0, '0, '0);
    oe_n = 1'b1;
    #1 check("R8 oe_n forces release", DW'(dq_oe), DW'(0));
    oe_n = 1'b0;
    #1 check("R8 drive returns", DW'(dq_oe), DW'(1));
    tick();

    // R9: sleep blocks commands
    sleep = 1'b1;
    cmd(1'b0, 1'b1, 1'b1, 4'd6, 4'hF);
    tick();
    cmd(1'b0, 1'b0, 1'b1, 4'd6, '0);
    wr_data = '0;
    tick();
    wr_data = JUNK;
    tick();
    check("R9 read during sleep", DW'(dq_oe), DW'(0));
    sleep = 1'b0;
    tick();
    check("R9 read after sleep oe", DW'(dq_oe), DW'(1));
    check("R9 contents kept", dq_o, refm[6]);

    // R1: command under reset ignored
    cmd(1'b0, 1'b0, 1'b0, '0, '0);
    tick();
    rst = 1'b1;
    cmd(1'b0, 1'b0, 1'b1, 4'd6, '0);
    tick();
    check("R1 read under reset", DW'(dq_oe), DW'(0));
    rst = 1'b0;
    cmd(1'b0, 1'b0, 1'b0, '0, '0);
    tick();

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule